// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block is one small logic cell of a programmable-logic fabric. It accepts 18 routed logic inputs and evaluates a shared pool of configurable AND terms. Twenty of the terms feed the data paths. Three more are reserved to act as a register clock, a register clear and an output-enable. Each of the four outputs has two possible sources. The first is a short path that ORs a fixed group of four terms. The second is a wide path that ORs any chosen subset of the twenty terms and then passes the result through an XOR with a configurable operand. After either path, each output is either passed straight through or held in a register.

All configuration arrives on static ports and must stay constant while the cell runs. Every register is clocked by the single system clock. The term-derived clock works as a load enable on that clock, and it is triggered by a rising transition of its term. The global reset is asynchronous and active high. The term-derived clear is synchronous.

Top module: `pterm_cell`

## Requirements
- R1: Each term has a two-bit code per input. Bit 0 set requires that input high, bit 1 set requires it low, code 00 ignores the input, and code 11 forces the term false. A term whose codes are all 00 is true.
- R2: In wide mode, the OR part of output k is the OR of data terms j (0 to 19) for which bit j of cfgSumMask[k] is set. An all-zero mask gives 0.
- R3: In wide mode, output k is that OR XORed with an operand. The operand is (cfgXorMode[k][1] AND data term cfgXorSel[k]) XOR cfgXorMode[k][0]. A select value of 20 or more reads as 0.
- R4: In short mode (cfgBypass[k]=1), output k is the OR of data terms 4k to 4k+3, and the XOR operand has no effect.
- R5: An output configured as combinational (cfgRegistered[k]=0) follows the inputs within the same cycle, with no clock edge involved.
- R6: With cfgClkSel=0, a registered output shows, after each clock edge, the value its selected path had just before that edge.
- R7: With cfgClkSel=1, registers load only on clock edges where clock term 20 is true and was false at the previous edge. At other edges they hold. The first edge after reset never loads.
- R8: With cfgRstEn=1, a true clear term 21 zeroes every register at the next edge, and this overrides loading. With cfgRstEn=0, term 21 has no effect.
- R9: Global reset rst clears every register asynchronously. Registered outputs read 0 while it is held and at the first edge after release.
- R10: oeOut equals term 22 combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| inVec | input | 18 | Routed logic inputs |
| cfgTerm | input | 23x18x2 | Per-term, per-input literal codes (terms 0-19 data, 20 clock, 21 clear, 22 enable) |
| cfgSumMask | input | 4x20 | Per-output selection of data terms for the wide path |
| cfgXorMode | input | 4x2 | Per-output XOR operand: bit 1 uses a term, bit 0 inverts |
| cfgXorSel | input | 4x5 | Per-output index of the XOR operand term |
| cfgBypass | input | 4 | Per-output choice of the short four-term path |
| cfgRegistered | input | 4 | Per-output choice of registered output |
| cfgClkSel | input | 1 | Registers load on clock-term rising transitions instead of every edge |
| cfgRstEn | input | 1 | Enables the clear term |
| dataOut | output | 4 | Cell outputs |
| oeOut | output | 1 | Output-enable term toward the I/O cells |

## Verification
The assertions check the register behaviour on every cycle. With the system clock as the load source, a register takes its path value. Under the term clock, a register holds its value on any edge without a rising clock term. A clear empties it, and after global reset it reads zero. The values of the logic itself can only be shown by the bench's scenarios. These are the literal codes, the mask selection, the XOR operand choice including out-of-range selects, the four-term groups of the short path and the enable term. For these, the bench sweeps each input against every code and runs pseudo-random input streams through several configurations, comparing against a mask-arithmetic model.

// File: rtl/pterm_pkg.sv
package pterm_pkg;
  localparam int DEF_NUM_IN  = 18;
  localparam int DEF_NUM_OUT = 4;
  localparam int DEF_NUM_SUM = 20;
  localparam int DEF_BYP_W   = 4;

  // strobes from control to datapath registers
  typedef struct packed {
    logic capture;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/pterm_ctrl.sv
module pterm_ctrl
  import pterm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cfgClkSel,
  input  logic    cfgRstEn,
  input  logic    ptClk,
  input  logic    ptRst,
  output strobe_t strobe
);
  logic clkPrev;

  // previous clock-term level; reset high so release never looks like an edge
  always_ff @(posedge clk or posedge rst) begin
    if (rst) clkPrev <= 1'b1;
    else     clkPrev <= ptClk;
  end

  always_comb begin
    strobe.capture = cfgClkSel ? (ptClk & ~clkPrev) : 1'b1;
    strobe.clear   = cfgRstEn & ptRst;
  end
endmodule

// File: rtl/pterm_datapath.sv
module pterm_datapath
  import pterm_pkg::*;
#(
  parameter  int NUM_IN   = DEF_NUM_IN,
  parameter  int NUM_OUT  = DEF_NUM_OUT,
  parameter  int NUM_SUM  = DEF_NUM_SUM,
  parameter  int BYP_W    = DEF_BYP_W,
  localparam int NUM_TERM = NUM_SUM + 3,
  localparam int SEL_W    = $clog2(NUM_SUM),
  localparam int PAD_W    = 1 << SEL_W
)(
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NUM_IN-1:0]                    inVec,
  input  logic [NUM_TERM-1:0][NUM_IN-1:0][1:0] cfgTerm,
  input  logic [NUM_OUT-1:0][NUM_SUM-1:0]      cfgSumMask,
  input  logic [NUM_OUT-1:0][1:0]              cfgXorMode,
  input  logic [NUM_OUT-1:0][SEL_W-1:0]        cfgXorSel,
  input  logic [NUM_OUT-1:0]                   cfgBypass,
  input  logic [NUM_OUT-1:0]                   cfgRegistered,
  input  strobe_t                              strobe,
  output logic                                 ptClk,
  output logic                                 ptRst,
  output logic                                 ptOe,
  output logic [NUM_OUT-1:0]                   comboOut,
  output logic [NUM_OUT-1:0]                   dataOut
);
  logic [NUM_TERM-1:0] termVec;
  logic [PAD_W-1:0]    sumPad;

  // AND array: each input contributes a literal per its two-bit code
  always_comb begin
    termVec = '1;
    for (int t = 0; t < NUM_TERM; t++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (cfgTerm[t][i][0] && !inVec[i]) termVec[t] = 1'b0;
        if (cfgTerm[t][i][1] &&  inVec[i]) termVec[t] = 1'b0;
      end
    end
  end

  assign ptClk  = termVec[NUM_SUM];
  assign ptRst  = termVec[NUM_SUM + 1];
  assign ptOe   = termVec[NUM_SUM + 2];
  // out-of-range operand selects land on zero padding
  assign sumPad = PAD_W'(termVec[NUM_SUM-1:0]);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    logic wideOr, xorOperand, shortOr, regQ;

    assign wideOr     = |(termVec[NUM_SUM-1:0] & cfgSumMask[k]);
    assign xorOperand = (cfgXorMode[k][1] & sumPad[cfgXorSel[k]]) ^ cfgXorMode[k][0];
    assign shortOr    = |termVec[k*BYP_W +: BYP_W];
    assign comboOut[k] = cfgBypass[k] ? shortOr : (wideOr ^ xorOperand);

    always_ff @(posedge clk or posedge rst) begin
      if (rst)                 regQ <= 1'b0;
      else if (strobe.clear)   regQ <= 1'b0;
      else if (strobe.capture) regQ <= comboOut[k];
    end

    assign dataOut[k] = cfgRegistered[k] ? regQ : comboOut[k];
  end
endmodule

// File: rtl/pterm_cell.sv
module pterm_cell
  import pterm_pkg::*;
#(
  parameter  int NUM_IN   = DEF_NUM_IN,
  parameter  int NUM_OUT  = DEF_NUM_OUT,
  parameter  int NUM_SUM  = DEF_NUM_SUM,
  parameter  int BYP_W    = DEF_BYP_W,
  localparam int NUM_TERM = NUM_SUM + 3,
  localparam int SEL_W    = $clog2(NUM_SUM)
)(
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NUM_IN-1:0]                    inVec,
  input  logic [NUM_TERM-1:0][NUM_IN-1:0][1:0] cfgTerm,
  input  logic [NUM_OUT-1:0][NUM_SUM-1:0]      cfgSumMask,
  input  logic [NUM_OUT-1:0][1:0]              cfgXorMode,
  input  logic [NUM_OUT-1:0][SEL_W-1:0]        cfgXorSel,
  input  logic [NUM_OUT-1:0]                   cfgBypass,
  input  logic [NUM_OUT-1:0]                   cfgRegistered,
  input  logic                                 cfgClkSel,
  input  logic                                 cfgRstEn,
  output logic [NUM_OUT-1:0]                   dataOut,
  output logic                                 oeOut
);
  strobe_t             strobe;
  logic                ptClkTerm, ptRstTerm;
  logic [NUM_OUT-1:0]  comboOut;

  pterm_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfgClkSel (cfgClkSel),
    .cfgRstEn  (cfgRstEn),
    .ptClk     (ptClkTerm),
    .ptRst     (ptRstTerm),
    .strobe    (strobe)
  );

  pterm_datapath #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .NUM_SUM (NUM_SUM),
    .BYP_W   (BYP_W)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .inVec         (inVec),
    .cfgTerm       (cfgTerm),
    .cfgSumMask    (cfgSumMask),
    .cfgXorMode    (cfgXorMode),
    .cfgXorSel     (cfgXorSel),
    .cfgBypass     (cfgBypass),
    .cfgRegistered (cfgRegistered),
    .strobe        (strobe),
    .ptClk         (ptClkTerm),
    .ptRst         (ptRstTerm),
    .ptOe          (oeOut),
    .comboOut      (comboOut),
    .dataOut       (dataOut)
  );
endmodule

// File: rtl/pterm_cell_chk.sv
module pterm_cell_chk
  import pterm_pkg::*;
#(
  parameter int NUM_OUT = DEF_NUM_OUT
)(
  input logic               clk,
  input logic               rst,
  input logic [NUM_OUT-1:0] cfgRegistered,
  input logic               cfgClkSel,
  input logic [NUM_OUT-1:0] comboOut,
  input logic [NUM_OUT-1:0] dataOut,
  input logic               ptClk,
  input strobe_t            strobe
);
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
    AST_GLOBAL_LOAD: assert property (@(posedge clk) disable iff (rst)
      cfgRegistered[k] && !cfgClkSel && !strobe.clear |=> dataOut[k] == $past(comboOut[k])); // R6
    AST_TERM_CLOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
      cfgRegistered[k] && cfgClkSel && !$rose(ptClk) && !strobe.clear |=> $stable(dataOut[k])); // R7
    AST_TERM_CLEAR: assert property (@(posedge clk) disable iff (rst)
      cfgRegistered[k] && strobe.clear |=> !dataOut[k]); // R8
    AST_RESET_RELEASE_ZERO: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) && cfgRegistered[k] |-> !dataOut[k]); // R9
  end
endmodule

bind pterm_cell pterm_cell_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfgRegistered (cfgRegistered),
  .cfgClkSel     (cfgClkSel),
  .comboOut      (comboOut),
  .dataOut       (dataOut),
  .ptClk         (ptClkTerm),
  .strobe        (strobe)
);

// File: tb/pterm_cell_tb.sv
module pterm_cell_tb;
  import pterm_pkg::*;
  localparam int NI = DEF_NUM_IN;
  localparam int NO = DEF_NUM_OUT;
  localparam int NS = DEF_NUM_SUM;
  localparam int BW = DEF_BYP_W;
  localparam int NT = NS + 3;
  localparam int SW = $clog2(NS);
  localparam int T_CLK = NS;
  localparam int T_RST = NS + 1;
  localparam int T_OE  = NS + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0]               inVec = '0;
  logic [NT-1:0][NI-1:0][1:0]  cfgTerm = '0;
  logic [NO-1:0][NS-1:0]       cfgSumMask = '0;
  logic [NO-1:0][1:0]          cfgXorMode = '0;
  logic [NO-1:0][SW-1:0]       cfgXorSel = '0;
  logic [NO-1:0]               cfgBypass = '0;
  logic [NO-1:0]               cfgRegistered = '0;
  logic                        cfgClkSel = 1'b0;
  logic                        cfgRstEn = 1'b0;
  logic [NO-1:0]               dataOut;
  logic                        oeOut;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1234_5679;
  logic [NO-1:0] expReg = '0;
  logic prevC = 1'b1;

  always #10 clk = ~clk;

  pterm_cell u_dut (
    .clk(clk), .rst(rst), .inVec(inVec), .cfgTerm(cfgTerm), .cfgSumMask(cfgSumMask),
    .cfgXorMode(cfgXorMode), .cfgXorSel(cfgXorSel), .cfgBypass(cfgBypass),
    .cfgRegistered(cfgRegistered), .cfgClkSel(cfgClkSel), .cfgRstEn(cfgRstEn),
    .dataOut(dataOut), .oeOut(oeOut)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      nFail++;
      $display("FAIL watchdog: actual cycles=%0d expected below=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  function automatic logic [31:0] rnd32();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  // term value from required-high / required-low masks
  function automatic logic termOf(int t, logic [NI-1:0] x);
    logic [NI-1:0] hi = '0;
    logic [NI-1:0] lo = '0;
    for (int i = 0; i < NI; i++) begin
      hi[i] = cfgTerm[t][i][0];
      lo[i] = cfgTerm[t][i][1];
    end
    return ((x & hi) == hi) && ((x & lo) == '0);
  endfunction

  function automatic logic comboOf(int k, logic [NI-1:0] x);
    logic [NS-1:0] tv;
    logic op;
    for (int t = 0; t < NS; t++) tv[t] = termOf(t, x);
    if (cfgBypass[k]) return |tv[k*BW +: BW];
    op = cfgXorMode[k][0];
    if (cfgXorMode[k][1] && int'(cfgXorSel[k]) < NS) op ^= tv[cfgXorSel[k]];
    return (|(tv & cfgSumMask[k])) ^ op;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cfgRound(int r);
    cfgTerm = '0;
    for (int t = 0; t < NT; t++) begin
      int hi = (t * 7 + r) % NI;
      int lo = (t * 5 + 3 + 2 * r) % NI;
      if (lo == hi) lo = (lo + 1) % NI;
      cfgTerm[t][hi] = 2'b01;
      cfgTerm[t][lo] = 2'b10;
    end
    for (int k = 0; k < NO; k++) begin
      cfgSumMask[k] = NS'(rnd32() & rnd32() & rnd32());
      cfgXorMode[k] = 2'((r + k) % 4);
      cfgXorSel[k]  = SW'((r * 3 + k * 7) % 32);
    end
    cfgBypass = '0;
    cfgRegistered = '0;
    cfgClkSel = 1'b0;
    cfgRstEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    #3 rst = 1'b1;
    #1;
    for (int k = 0; k < NO; k++)
      if (cfgRegistered[k]) chk("R9 async clear", dataOut[k], 1'b0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    expReg = '0;
    prevC = 1'b1;
  endtask

  // one vector per clock; model tracks register state per the requirements
  task automatic run(string tag, int n);
    for (int v = 0; v < n; v++) begin
      logic [NI-1:0] x;
      logic c, cap;
      x = NI'(rnd32());
      inVec = x;
      c = termOf(T_CLK, x);
      cap = cfgClkSel ? (c && !prevC) : 1'b1;
      prevC = c;
      for (int k = 0; k < NO; k++) begin
        if (cfgRstEn && termOf(T_RST, x)) expReg[k] = 1'b0;
        else if (cap) expReg[k] = comboOf(k, x);
      end
      @(negedge clk);
      for (int k = 0; k < NO; k++)
        chk(tag, dataOut[k], cfgRegistered[k] ? expReg[k] : comboOf(k, x));
      chk("R10 enable term", oeOut, termOf(T_OE, x));
    end
  endtask

  // every input against every literal code, no clock edge between drive and check
  task automatic sweepR1();
    cfgTerm = '0;
    cfgSumMask = '0;
    cfgSumMask[0][0] = 1'b1;
    cfgXorMode = '0;
    cfgBypass = '0;
    cfgRegistered = '0;
    for (int i = 0; i < NI; i++) begin
      for (int enc = 0; enc < 4; enc++) begin
        for (int b = 0; b < 2; b++) begin
          logic [NI-1:0] x;
          logic exp;
          @(negedge clk);
          cfgTerm[0] = '0;
          cfgTerm[0][i] = 2'(enc);
          x = NI'(rnd32());
          x[i] = 1'(b);
          inVec = x;
          exp = (enc == 0) ? 1'b1 : (enc == 1) ? 1'(b) : (enc == 2) ? ~1'(b) : 1'b0;
          #2;
          chk("R1 R5 literal code", dataOut[0], exp);
        end
      end
    end
    chk("R1 empty term", oeOut, 1'b1);
  endtask

  initial begin
    cfgRound(0);
    cfgRegistered = '1;
    inVec = '1;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < NO; k++) chk("R9 held reset", dataOut[k], 1'b0);
    rst = 1'b0;

    sweepR1();

    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      cfgRound(r);
      run("R2 R3 R5 wide path", 64);
    end

    @(negedge clk);
    cfgRound(2);
    cfgBypass = '1;
    run("R4 short path", 64);

    cfgRound(3);
    cfgBypass = 4'b1010;
    cfgRegistered = 4'b0011;
    doReset();
    run("R6 system clock load", 100);

    cfgRound(1);
    cfgRegistered = '1;
    cfgClkSel = 1'b1;
    cfgTerm[T_CLK] = '0;
    cfgTerm[T_CLK][17] = 2'b01;
    doReset();
    run("R7 term clock", 200);

    cfgRound(1);
    cfgRegistered = '1;
    cfgRstEn = 1'b1;
    cfgTerm[T_RST] = '0;
    cfgTerm[T_RST][16] = 2'b01;
    cfgTerm[T_RST][15] = 2'b01;
    doReset();
    run("R8 clear term", 150);
    cfgRstEn = 1'b0;
    doReset();
    run("R8 clear disabled", 100);
    doReset();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule